// File: doc/BRIEF.md
# Two-Channel Fractional-Count Pulse-Width Modulator

This block drives two pulse-width-modulated outputs from two externally supplied 8-bit timers. Each timer reports its count, a one-cycle strobe in the first cycle of every period, and whether it is advanced by an external clock. The timers themselves sit outside the block. Each channel compares a 10-bit duty value with the selected timer's count. That count is widened by two phase bits, which the block runs in step with the four-clock prescale of an internally clocked timer. Channel 0 always follows timer 1. Channel 1 follows whichever timer its select bit names.

Software sets the duty values, the time-base select and the enables through a write-only configuration port. A channel loads its duty value only at the start of its time base's period. A write made mid-period therefore never cuts a pulse short or stretches it.

When the selected timer runs from an external clock, the phase bits cannot be trusted. In that case the two fractional duty bits are forced to zero and resolution falls to 8 bits.

Top module: `pwm_dual`

## Requirements
- R1: After reset, both outputs are low, both enables are clear, and every duty value is zero. Enabling a channel without writing a duty value keeps its output low.
- R2: The duty value of channel c is 10 bits. Bits 9:2 come from the byte written to address 1+2c. Bits 1:0 come from bits 7:6 of the byte written to address 2+2c. With an internally clocked time base (four clocks per count), the output stays high for exactly duty clocks per period.
- R3: With a nonzero duty value, the output rises on the clock edge that follows the period-start strobe of its time base. It never rises at any other time.
- R4: A duty value of zero keeps the output low for the whole period.
- R5: If the duty value is at or above the period length in sub-counts, the output stays high for the whole period.
- R6: A duty value written mid-period takes effect at the next period start. The period in progress keeps the old high time.
- R7: Enable bit c is bit c of the byte at address 0. Clearing it drives output c low within two clocks of the write being accepted and keeps it low. After the bit is set again, pulses resume at the next period start.
- R8: When the selected time base reports an external clock, duty bits 1:0 are ignored. The output stays high for duty[9:2] timer counts.
- R9: Bit 0 of the byte at address 2+2c selects the time base of channel c≥1: 0 selects timer 1 and 1 selects timer 2. Channel 0 always uses timer 1.
- R10: The configuration port never applies back-pressure. cfg_ready stays high, and a write takes effect in the clock where cfg_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Write accepted (always high) |
| cfg_addr | input | 3 | Register address |
| cfg_data | input | 8 | Register write data |
| tmr1_cnt | input | 8 | Timer 1 count |
| tmr1_wrap | input | 1 | Timer 1 period-start strobe |
| tmr1_ext | input | 1 | Timer 1 runs from an external clock |
| tmr2_cnt | input | 8 | Timer 2 count |
| tmr2_wrap | input | 1 | Timer 2 period-start strobe |
| tmr2_ext | input | 1 | Timer 2 runs from an external clock |
| pwm_out | output | 2 | PWM outputs, one bit per channel |

## Verification
The bench builds the block with its defaults: two channels, an 8-bit count and two phase bits. Timer 1 is modelled with an internal clock, a four-clock prescale and a 16-count period, which gives a 64-clock period. Every duty code from 1 to past the period end can then be measured in clocks. Timer 2 is modelled with an external clock that advances every three clocks, which gives a 48-clock period. This setting shows that the fractional duty bits are dropped and that high time is a whole number of timer counts.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  typedef enum logic {TB_T1 = 1'b0, TB_T2 = 1'b1} tb_sel_e;
  localparam int unsigned CTRL_ADDR = 0;
endpackage

// File: rtl/pwm_regfile.sv
`timescale 1ns/1ps
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  parameter int ADDR_W = 3,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [CNT_W-1:0]             data,
  output logic [NCH-1:0]               en,
  output logic [NCH-1:0][DUTY_W-1:0]   duty,
  output logic [NCH-1:0]               sel
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      en <= '0;
    else if (wr_en && addr == A_CTRL) en <= data[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(1 + 2*c);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 + 2*c);
    logic [CNT_W-1:0]  hi_q;
    logic [FRAC_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (wr_en) begin
        if (addr == A_HI) hi_q <= data;
        if (addr == A_LO) lo_q <= data[CNT_W-1 -: FRAC_W];
      end
    end
    assign duty[c] = {hi_q, lo_q};

    if (c == 0) begin : g_fixed
      assign sel[c] = TB_T1;
    end else begin : g_sel
      logic sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     sel_q <= TB_T1;
        else if (wr_en && addr == A_LO) sel_q <= data[0];
      end
      assign sel[c] = sel_q;
    end
  end
endmodule

// File: rtl/pwm_phase.sv
`timescale 1ns/1ps
module pwm_phase #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int XW = CNT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic             ext,
  output logic [XW-1:0]    xcnt
);
  logic [FRAC_W-1:0] ph_q, ph_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= '0;
    else if (wrap) ph_q <= FRAC_W'(1);
    else           ph_q <= ph_q + 1'b1;
  end

  always_comb begin
    ph_eff = ph_q;
    if (wrap || ext) ph_eff = '0;
  end

  assign xcnt = {cnt, ph_eff};
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DUTY_W-1:0] duty,
  input  logic              sel,
  input  logic [DUTY_W-1:0] xcnt_a,
  input  logic              wrap_a,
  input  logic              ext_a,
  input  logic [DUTY_W-1:0] xcnt_b,
  input  logic              wrap_b,
  input  logic              ext_b,
  output logic              pwm
);
  logic [DUTY_W-1:0] xcnt, duty_next, act_q;
  logic              wrap, ext;

  always_comb begin
    if (sel == TB_T2) begin
      xcnt = xcnt_b; wrap = wrap_b; ext = ext_b;
    end else begin
      xcnt = xcnt_a; wrap = wrap_a; ext = ext_a;
    end
    duty_next = duty;
    if (ext) duty_next = {duty[DUTY_W-1:FRAC_W], {FRAC_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      pwm   <= 1'b0;
    end else begin
      if (wrap) act_q <= duty_next;
      if (!en)               pwm <= 1'b0;
      else if (wrap)         pwm <= (duty_next != '0);
      else if (xcnt == act_q) pwm <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_dual.sv
`timescale 1ns/1ps
module pwm_dual
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int ADDR_W = $clog2(2*NCH + 1),
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_data,
  input  logic [CNT_W-1:0]  tmr1_cnt,
  input  logic              tmr1_wrap,
  input  logic              tmr1_ext,
  input  logic [CNT_W-1:0]  tmr2_cnt,
  input  logic              tmr2_wrap,
  input  logic              tmr2_ext,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]             en, sel;
  logic [NCH-1:0][DUTY_W-1:0] duty;
  logic [DUTY_W-1:0]          x1, x2;

  assign cfg_ready = 1'b1;

  pwm_regfile #(.NCH(NCH), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_valid && cfg_ready), .addr(cfg_addr),
    .data(cfg_data), .en(en), .duty(duty), .sel(sel)
  );

  pwm_phase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_ph1 (
    .clk(clk), .rst_n(rst_n), .cnt(tmr1_cnt), .wrap(tmr1_wrap), .ext(tmr1_ext), .xcnt(x1)
  );
  pwm_phase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_ph2 (
    .clk(clk), .rst_n(rst_n), .cnt(tmr2_cnt), .wrap(tmr2_wrap), .ext(tmr2_ext), .xcnt(x2)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_channel #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en[c]), .duty(duty[c]), .sel(sel[c]),
      .xcnt_a(x1), .wrap_a(tmr1_wrap), .ext_a(tmr1_ext),
      .xcnt_b(x2), .wrap_b(tmr2_wrap), .ext_b(tmr2_ext),
      .pwm(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_dual_chk.sv
`timescale 1ns/1ps
module pwm_dual_chk #(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [CNT_W-1:0]  cfg_data,
  input logic              tmr1_wrap,
  input logic              tmr2_wrap,
  input logic [NCH-1:0]    pwm_out
);
  // R1
  known_chk: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown(pwm_out));

  // R9
  chan0_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr2_wrap && !tmr1_wrap) |=> !$rose(pwm_out[0]));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R7
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_addr == '0 && !cfg_data[c]) |=> ##1 !pwm_out[c]);
    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[c]) |-> $past(c == 0 ? tmr1_wrap : (tmr1_wrap || tmr2_wrap)));
  end
endmodule

bind pwm_dual pwm_dual_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
  .cfg_data(cfg_data), .tmr1_wrap(tmr1_wrap), .tmr2_wrap(tmr2_wrap), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_dual.sv
`timescale 1ns/1ps
module sim_pwm_dual;
  localparam int P1 = 64;  // timer 1: internal, /4, 16 counts
  localparam int P2 = 48;  // timer 2: external, /3, 16 counts

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_valid = 1'b0, cfg_ready;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [7:0] t1c = '0, t2c = '0;
  int         p1 = 0, p2 = 0;
  logic       run = 1'b0;
  logic       t1w, t2w;
  logic [1:0] pwm_out;
  int n_chk = 0, n_bad = 0;

  assign t1w = run && t1c == 0 && p1 == 0;
  assign t2w = run && t2c == 0 && p2 == 0;

  always #10 clk = ~clk;

  pwm_dual u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .tmr1_cnt(t1c), .tmr1_wrap(t1w), .tmr1_ext(1'b0),
    .tmr2_cnt(t2c), .tmr2_wrap(t2w), .tmr2_ext(1'b1),
    .pwm_out(pwm_out)
  );

  // simple timer models, updated on the falling edge
  initial begin
    wait (rst_n);
    @(negedge clk);
    run = 1'b1;
    forever begin
      @(negedge clk);
      if (p1 == 3) begin p1 = 0; t1c = (t1c == 15) ? 8'd0 : t1c + 8'd1; end
      else p1 = p1 + 1;
      if (p2 == 2) begin p2 = 0; t2c = (t2c == 15) ? 8'd0 : t2c + 8'd1; end
      else p2 = p2 + 1;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cfg_valid = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic set_duty(input int ch, input int val, input logic s);
    wr(3'(1 + 2*ch), 8'(val >> 2));
    wr(3'(2 + 2*ch), {2'(val), 5'd0, s});
  endtask

  task automatic wait_wrap(input int ch_tb);
    do begin @(negedge clk); #1; end while (!(ch_tb == 2 ? t2w : t1w));
  endtask

  task automatic measure(input int ch, input int tb, output int hi);
    int p;
    p = (tb == 2) ? P2 : P1;
    hi = 0;
    wait_wrap(tb);
    for (int i = 1; i <= p; i++) begin
      @(negedge clk); #1;
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic t_reset();
    int h;
    check("R1 outputs after reset", pwm_out, 0);
    check("R10 ready", cfg_ready, 1);
    wr(3'd0, 8'h03);
    measure(0, 1, h);
    check("R1 enabled with reset duty", h, 0);
  endtask

  task automatic t_duty_sweep();
    int h;
    set_duty(0, 1, 1'b0);    measure(0, 1, h); check("R3 duty 1", h, 1);
    set_duty(0, 37, 1'b0);   measure(0, 1, h); check("R2 duty 37", h, 37);
    set_duty(0, 63, 1'b0);   measure(0, 1, h); check("R2 duty 63", h, 63);
    set_duty(0, 64, 1'b0);   measure(0, 1, h); check("R5 duty 64", h, 64);
    set_duty(0, 1023, 1'b0); measure(0, 1, h); check("R5 duty 1023", h, 64);
    set_duty(0, 0, 1'b0);    measure(0, 1, h); check("R4 duty 0", h, 0);
  endtask

  task automatic t_latch();
    int h;
    set_duty(0, 40, 1'b0);
    measure(0, 1, h); check("R6 before change", h, 40);
    wait_wrap(1);
    h = 0;
    for (int i = 1; i <= P1; i++) begin
      @(negedge clk); #1;
      if (pwm_out[0]) h++;
      if (i == 3) begin cfg_valid = 1'b1; cfg_addr = 3'd1; cfg_data = 8'd2; end
      if (i == 4) begin cfg_addr = 3'd2; cfg_data = 8'h80; end
      if (i == 5) cfg_valid = 1'b0;
    end
    check("R6 period of the write", h, 40);
    measure(0, 1, h); check("R6 next period", h, 10);
  endtask

  task automatic t_enable();
    int h, rest;
    set_duty(0, 30, 1'b0);
    measure(0, 1, h); check("R7 enabled", h, 30);
    wait_wrap(1);
    rest = 0;
    for (int i = 1; i <= P1; i++) begin
      @(negedge clk); #1;
      if (i == 7) check("R7 low after disable", pwm_out[0], 0);
      if (i >= 7 && pwm_out[0]) rest++;
      if (i == 5) begin cfg_valid = 1'b1; cfg_addr = 3'd0; cfg_data = 8'h02; end
      if (i == 6) cfg_valid = 1'b0;
    end
    check("R7 held low rest of period", rest, 0);
    measure(0, 1, h); check("R7 disabled period", h, 0);
    wr(3'd0, 8'h03);
    measure(0, 1, h); check("R7 re-enabled", h, 30);
  endtask

  task automatic t_select();
    int h;
    set_duty(1, 22, 1'b0);
    measure(1, 1, h); check("R9 ch1 on timer 1", h, 22);
    set_duty(1, 23, 1'b1);
    measure(1, 2, h); check("R8 ch1 external low bits 3", h, 15);
    set_duty(1, 20, 1'b1);
    measure(1, 2, h); check("R8 ch1 external low bits 0", h, 15);
    measure(0, 1, h); check("R9 ch0 stays on timer 1", h, 30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 outputs in reset", pwm_out, 0);
    rst_n = 1'b1;
    t_reset();
    t_duty_sweep();
    t_latch();
    t_enable();
    t_select();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule